// File: doc/BRIEF.md
# Programmable Ones-Count Boolean Function Evaluator

This block evaluates an arbitrary Boolean function of `N_IN` inputs whose shape is loaded on parallel configuration inputs. The input vector is split into a high part of `N_IN-K_LO` bits and a low part of `K_LO` bits. For every value of the high part there is one fragment unit, so there are `2^(N_IN-K_LO)` units.

Each unit counts the ones in the low part and uses that count to pick one bit of its own `K_LO+1`-bit code word. The result is a symmetric function of the low bits. The unit then applies up to `N_CORR` single-vector patches, and each patch either forces the value to 1 or to 0 on one exact low-part vector. A product term over the high bits gates the patched value, and each high bit in that term has a programmable inverter.

The outputs of all units are ORed and the sum is registered. A host tool derives the configuration from a truth table; the block only evaluates it.

Top module: `posop_func_eval`

## Requirements
- R1: While `rst` is high, `f_out` is 0 at every rising edge, whatever the data and configuration inputs are.
- R2: With no enabled correction slot, a selected fragment `f` yields bit `m` of its code word, where `m` is the number of ones in `x_in[K_LO-1:0]`. Bit `m` of fragment `f` sits at `op_code[f*(K_LO+1)+m]`.
- R3: Fragment `f` is selected only when, for every high bit `t`, `x_in[K_LO+t]` equals the inverse of `hi_pol[f*(N_IN-K_LO)+t]`. A polarity bit of 1 therefore selects on an input of 0. An unselected fragment contributes 0.
- R4: Correction slot `s` of fragment `f` has index `i=f*N_CORR+s`. It matches only when `x_in[K_LO-1:0]` equals the bitwise inverse of `corr_pol[i*K_LO +: K_LO]`.
- R5: An enabled slot with `corr_kind` bit 1 forces a selected fragment to 1 on its matched vector.
- R6: An enabled slot with `corr_kind` bit 0 forces a selected fragment to 0 on its matched vector. It also takes precedence over any force-to-1 hit on the same vector.
- R7: A slot whose `corr_en` bit is 0 has no effect on the output, whatever its kind and polarity bits are.
- R8: `f_out` at a rising edge equals the OR of all fragment values computed from the inputs present just before that edge. This gives one cycle of latency.
- R9: An all-zero code word with all slots disabled gives `f_out` of 0 for every input vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | N_IN | Function argument; high part is `x_in[N_IN-1:K_LO]` |
| op_code | input | 2^(N_IN-K_LO)*(K_LO+1) | Code word per fragment, indexed by ones count |
| hi_pol | input | 2^(N_IN-K_LO)*(N_IN-K_LO) | High-bit inverter controls per fragment |
| corr_pol | input | 2^(N_IN-K_LO)*N_CORR*K_LO | Low-bit inverter controls per correction slot |
| corr_kind | input | 2^(N_IN-K_LO)*N_CORR | 1 = force to 1, 0 = force to 0 |
| corr_en | input | 2^(N_IN-K_LO)*N_CORR | Correction slot enable |
| f_out | output | 1 | Registered function value |

## Verification
The hardest case to reach from the ports is a correction slot whose matched vector lies inside a selected fragment and disagrees with the operator's value. Random configurations rarely line these up. Directed configurations therefore set the high-bit polarity of one fragment to the inverse of its index. They also place a force-to-1 patch on a vector where the code word gives 0, and a force-to-0 patch where it gives 1, and then sweep all `2^N_IN` argument vectors. Random configurations with a fixed seed cover the mixed cases, and a bench model derived from the requirements checks every vector.

// File: rtl/posop_pkg.sv
package posop_pkg;
  typedef enum logic {
    CORR_CLEAR = 1'b0,
    CORR_SET   = 1'b1
  } corr_kind_e;
endpackage

// File: rtl/posop_ones_count.sv
module posop_ones_count #(
  parameter int W = 3,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end

  always_comb begin
    AST_COUNT_RANGE: assert (32'(cnt) <= W); // R2
  end
endmodule

// File: rtl/posop_corr_match.sv
module posop_corr_match
  import posop_pkg::*;
#(
  parameter int K = 3
) (
  input  logic [K-1:0] lo,
  input  logic [K-1:0] pol,
  input  logic         kind,
  input  logic         en,
  output logic         hit_set,
  output logic         hit_clr
);
  logic [K-1:0] lit;
  logic         match;

  assign lit     = lo ^ pol;
  assign match   = &lit;
  assign hit_set = en & match & (corr_kind_e'(kind) == CORR_SET);
  assign hit_clr = en & match & (corr_kind_e'(kind) == CORR_CLEAR);
endmodule

// File: rtl/posop_frag.sv
module posop_frag #(
  parameter int K = 3,
  parameter int H = 2,
  parameter int L = 1,
  localparam int CW   = K + 1,
  localparam int CNTW = $clog2(K + 1)
) (
  input  logic [H-1:0]   x_hi,
  input  logic [K-1:0]   x_lo,
  input  logic [CW-1:0]  code,
  input  logic [H-1:0]   hpol,
  input  logic [L*K-1:0] cpol,
  input  logic [L-1:0]   ckind,
  input  logic [L-1:0]   cen,
  output logic           conj,
  output logic           op_val,
  output logic           any_set,
  output logic           any_clr,
  output logic           frag_val
);
  logic [CNTW-1:0] cnt;
  logic [L-1:0]    set_v;
  logic [L-1:0]    clr_v;

  posop_ones_count #(.W(K)) u_cnt (
    .vec (x_lo),
    .cnt (cnt)
  );

  for (genvar s = 0; s < L; s++) begin : g_slot
    posop_corr_match #(.K(K)) u_match (
      .lo      (x_lo),
      .pol     (cpol[s*K +: K]),
      .kind    (ckind[s]),
      .en      (cen[s]),
      .hit_set (set_v[s]),
      .hit_clr (clr_v[s])
    );
  end

  assign conj     = &(x_hi ^ hpol);
  assign op_val   = code[cnt];
  assign any_set  = |set_v;
  assign any_clr  = |clr_v;
  assign frag_val = conj & (op_val | any_set) & ~any_clr;
endmodule

// File: rtl/posop_func_eval.sv
module posop_func_eval #(
  parameter int N_IN   = 5,
  parameter int K_LO   = 3,
  parameter int N_CORR = 1,
  localparam int HB    = N_IN - K_LO,
  localparam int NFRAG = 1 << HB,
  localparam int CWID  = K_LO + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_IN-1:0]             x_in,
  input  logic [NFRAG*CWID-1:0]       op_code,
  input  logic [NFRAG*HB-1:0]         hi_pol,
  input  logic [NFRAG*N_CORR*K_LO-1:0] corr_pol,
  input  logic [NFRAG*N_CORR-1:0]     corr_kind,
  input  logic [NFRAG*N_CORR-1:0]     corr_en,
  output logic                        f_out
);
  logic [NFRAG-1:0] frag_conj;
  logic [NFRAG-1:0] frag_op;
  logic [NFRAG-1:0] frag_set;
  logic [NFRAG-1:0] frag_clr;
  logic [NFRAG-1:0] frag_val;

  for (genvar f = 0; f < NFRAG; f++) begin : g_frag
    posop_frag #(.K(K_LO), .H(HB), .L(N_CORR)) u_frag (
      .x_hi     (x_in[N_IN-1:K_LO]),
      .x_lo     (x_in[K_LO-1:0]),
      .code     (op_code[f*CWID +: CWID]),
      .hpol     (hi_pol[f*HB +: HB]),
      .cpol     (corr_pol[f*N_CORR*K_LO +: N_CORR*K_LO]),
      .ckind    (corr_kind[f*N_CORR +: N_CORR]),
      .cen      (corr_en[f*N_CORR +: N_CORR]),
      .conj     (frag_conj[f]),
      .op_val   (frag_op[f]),
      .any_set  (frag_set[f]),
      .any_clr  (frag_clr[f]),
      .frag_val (frag_val[f])
    );

    AST_NO_CORR_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
      !(|corr_en[f*N_CORR +: N_CORR]) |-> frag_val[f] == (frag_op[f] & frag_conj[f])); // R7
    AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (rst)
      (frag_conj[f] && frag_set[f] && !frag_clr[f]) |-> frag_val[f]); // R5
    AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (rst)
      frag_clr[f] |-> !frag_val[f]); // R6
  end

  always_ff @(posedge clk) begin
    if (rst) f_out <= 1'b0;
    else     f_out <= |frag_val;
  end

  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
    !(|frag_conj) |=> !f_out); // R3
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> f_out == $past(|frag_val)); // R8
endmodule

// File: tb/posop_func_eval_bench.sv
module posop_func_eval_bench;
  localparam int N  = 5;
  localparam int K  = 3;
  localparam int L  = 1;
  localparam int H  = N - K;
  localparam int NF = 1 << H;
  localparam int CW = K + 1;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [N-1:0]        x_in = '0;
  logic [NF*CW-1:0]    op_code = '0;
  logic [NF*H-1:0]     hi_pol = '0;
  logic [NF*L*K-1:0]   corr_pol = '0;
  logic [NF*L-1:0]     corr_kind = '0;
  logic [NF*L-1:0]     corr_en = '0;
  logic                f_out;

  int nvec = 0;
  int nmis = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  posop_func_eval #(.N_IN(N), .K_LO(K), .N_CORR(L)) u_posop_func_eval (
    .clk(clk), .rst(rst), .x_in(x_in), .op_code(op_code), .hi_pol(hi_pol),
    .corr_pol(corr_pol), .corr_kind(corr_kind), .corr_en(corr_en), .f_out(f_out)
  );

  function automatic logic ref_eval(input logic [N-1:0] x);
    logic res = 1'b0;
    for (int f = 0; f < NF; f++) begin
      logic sel = 1'b1;
      int   ones = 0;
      logic v, fs = 1'b0, fc = 1'b0;
      for (int t = 0; t < H; t++)
        if (x[K+t] == hi_pol[f*H+t]) sel = 1'b0;
      for (int b = 0; b < K; b++) ones += int'(x[b]);
      v = op_code[f*CW + ones];
      for (int s = 0; s < L; s++) begin
        int  i = f*L + s;
        logic hit = 1'b1;
        for (int b = 0; b < K; b++)
          if (x[b] == corr_pol[i*K+b]) hit = 1'b0;
        if (corr_en[i] && hit) begin
          if (corr_kind[i]) fs = 1'b1;
          else              fc = 1'b1;
        end
      end
      v = (v | fs) & ~fc;
      res = res | (sel & v);
    end
    return res;
  endfunction

  task automatic check_vec(input string tag, input logic [N-1:0] x);
    logic exp;
    @(negedge clk);
    x_in = x;
    exp  = ref_eval(x);
    @(posedge clk);
    #1;
    nvec++;
    if (f_out !== exp) begin
      nmis++;
      $display("FAIL %s x=%0d got %b expected %b", tag, x, f_out, exp);
    end
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < (1 << N); v++) check_vec(tag, N'(v));
  endtask

  task automatic clear_cfg();
    @(negedge clk);
    op_code = '0; corr_pol = '0; corr_kind = '0; corr_en = '0;
    for (int f = 0; f < NF; f++) hi_pol[f*H +: H] = ~H'(f);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    nmis++;
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: drive a configuration that is 1 everywhere while in reset
    op_code = '1;
    for (int f = 0; f < NF; f++) hi_pol[f*H +: H] = ~H'(f);
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      x_in = N'(v * 7);
      @(posedge clk);
      #1;
      nvec++;
      if (f_out !== 1'b0) begin
        nmis++;
        $display("FAIL R1 reset output got %b expected 0", f_out);
      end
    end
    @(negedge clk);
    rst = 1'b0;
    sweep("R8 all-ones");

    // R9: all-zero configuration
    clear_cfg();
    sweep("R9");

    // R3: only fragment 2 carries ones, selected on its own index
    clear_cfg();
    op_code[2*CW +: CW] = '1;
    sweep("R3");
    // R3: polarity of 1 selects on input 0 (all pols set, only hi=0 selects)
    clear_cfg();
    op_code = '1;
    hi_pol  = '1;
    sweep("R3 polarity");

    // R2: symmetric operator per fragment
    for (int r = 0; r < 6; r++) begin
      clear_cfg();
      op_code = (NF*CW)'({$urandom, $urandom});
      sweep("R2");
    end

    // R4 R5: force-1 on low vector 5 in fragment 1, operator 0
    clear_cfg();
    corr_en[1*L] = 1'b1; corr_kind[1*L] = 1'b1;
    corr_pol[1*L*K +: K] = ~K'(5);
    sweep("R4 R5");

    // R6: force-0 on low vector 3 in fragment 3, operator all ones
    clear_cfg();
    op_code = '1;
    corr_en[3*L] = 1'b1; corr_kind[3*L] = 1'b0;
    corr_pol[3*L*K +: K] = ~K'(3);
    sweep("R6");

    // R7: disabled slots with random kind and polarity
    for (int r = 0; r < 4; r++) begin
      clear_cfg();
      op_code   = (NF*CW)'({$urandom, $urandom});
      corr_pol  = (NF*L*K)'($urandom);
      corr_kind = (NF*L)'($urandom);
      sweep("R7");
    end

    // R8: fully random configurations
    for (int r = 0; r < 30; r++) begin
      @(negedge clk);
      op_code   = (NF*CW)'({$urandom, $urandom});
      hi_pol    = (NF*H)'($urandom);
      corr_pol  = (NF*L*K)'($urandom);
      corr_kind = (NF*L)'($urandom);
      corr_en   = (NF*L)'($urandom);
      sweep("R8");
    end

    finish_run();
  end
endmodule